// File: doc/BRIEF.md
# Overrange Detector with Sticky Status

This block watches the signed samples coming out of the first decimation stage of a sigma-delta converter. That stage delivers a new sample once every four internal clocks. The block compares the magnitude of each sample with a 16-bit programmable limit and gives two views of the same condition. The first is a live alarm pin that follows every stage-1 sample. The second is a status bit that records whether any sample in the current output-word period went past the limit, and it is refreshed once per output word.

The block also watches a flag that runs at the modulator rate and marks a raw sample as beyond full scale. If that flag stays high for more than four consecutive modulator samples, the alarm is raised at once. It does not wait for the next stage-1 sample. Whenever either view reports overrange, the block asks the converter to drop its filter-settled flag. A synchronous sync input and an asynchronous reset both return the block to a clean state.

Top module: `ovr_watch`

## Requirements
- R1: While reset is low, or on any clock edge with `sync_n` low, the pin, the status bit, the sticky accumulator and the consecutive-flag counter are cleared. All outputs read 0 afterwards.
- R2: The magnitude of `s1_data` is its two's-complement absolute value. The most negative code is saturated to the largest positive magnitude. Bits [SW-2:SW-1-TW] of the magnitude are compared with `thresh`, and a sample is over only if that field is strictly greater than `thresh`. With the defaults, 0x666600 is not over a limit of 0xCCCC and 0x666680 is over it.
- R3: On each clock with `s1_valid` high, `ovr_pin` takes the over/not-over result of that sample after the edge. With no valid sample and no fast override, the pin holds its value.
- R4: On each clock with `word_stb` high, `ovr_stat` takes the OR of every over result since the previous strobe, including a sample or fast override in the strobe cycle itself. Between strobes `ovr_stat` holds.
- R5: The accumulator is cleared at the strobe, after its value has been copied. An excursion counted into one word never appears in the next word.
- R6: When `mod_fs` is high for a fifth consecutive clock, or any later one in the same run, `ovr_pin` is 1 after that edge and the excursion enters the accumulator. This takes priority over a not-over stage-1 sample in the same cycle.
- R7: A run of four or fewer consecutive `mod_fs` clocks, or a run broken by a single low clock, does not raise the pin.
- R8: `settle_clr` is high whenever `ovr_pin` or `ovr_stat` is high, and low otherwise.
- R9: A new value on `thresh` applies to the next valid sample, with no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Synchronous active-low clear, held low during sync |
| s1_valid | input | 1 | Stage-1 sample strobe |
| s1_data | input | SW | Signed stage-1 sample |
| thresh | input | TW | Overrange limit, 0xCCCC is 80 % of reference |
| mod_fs | input | 1 | Modulator sample beyond full scale |
| word_stb | input | 1 | One pulse per output word |
| ovr_pin | output | 1 | Live overrange alarm |
| ovr_stat | output | 1 | Overrange status for the last output word |
| settle_clr | output | 1 | Request to force the filter-settled flag low |

## Verification
An output-word strobe can fall in the same cycle as an over-limit stage-1 sample or a fifth consecutive full-scale flag. The bench forces both collisions on purpose. It then expects the excursion in the status of the word that is closing and not in the next one. A fifth full-scale flag is also made to coincide with a below-limit stage-1 sample, and the pin must read high. A behavioural reference model runs alongside for thousands of random cycles. That stimulus includes bursts of `mod_fs`, strobes and threshold changes, so these coincidences also arise on their own, and the model judges them.

// File: rtl/ovr_watch.sv
module ovr_watch #(
  parameter int SW  = 24,
  parameter int TW  = 16,
  parameter int RUN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_n,
  input  logic          s1_valid,
  input  logic [SW-1:0] s1_data,
  input  logic [TW-1:0] thresh,
  input  logic          mod_fs,
  input  logic          word_stb,
  output logic          ovr_pin,
  output logic          ovr_stat,
  output logic          settle_clr
);
  localparam int FSW = $clog2(RUN + 1);
  localparam logic [SW-1:0] MOST_NEG = {1'b1, {(SW-1){1'b0}}};
  localparam logic [SW-1:0] MOST_POS = {1'b0, {(SW-1){1'b1}}};

  logic [SW-1:0]  mag;
  logic [TW-1:0]  mag_hi;
  logic           over, fast, hit, sticky;
  logic [FSW-1:0] fs_cnt;

  assign mag    = (s1_data == MOST_NEG) ? MOST_POS :
                  s1_data[SW-1] ? (~s1_data + 1'b1) : s1_data;
  assign mag_hi = mag[SW-2 -: TW];
  assign over   = mag_hi > thresh;
  assign fast   = mod_fs && (fs_cnt == FSW'(RUN));
  assign hit    = (s1_valid && over) || fast;
  assign settle_clr = ovr_pin | ovr_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             fs_cnt <= '0;
    else if (!sync_n)       fs_cnt <= '0;
    else if (!mod_fs)       fs_cnt <= '0;
    else if (fs_cnt < FSW'(RUN)) fs_cnt <= fs_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovr_pin <= 1'b0;
    else if (!sync_n)  ovr_pin <= 1'b0;
    else if (fast)     ovr_pin <= 1'b1;
    else if (s1_valid) ovr_pin <= over;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky   <= 1'b0;
      ovr_stat <= 1'b0;
    end else if (!sync_n) begin
      sticky   <= 1'b0;
      ovr_stat <= 1'b0;
    end else if (word_stb) begin
      ovr_stat <= sticky | hit;
      sticky   <= 1'b0;
    end else if (hit) begin
      sticky   <= 1'b1;
    end
  end

  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> (!ovr_pin && !ovr_stat && fs_cnt == '0)); // R1
  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_n && !s1_valid && !mod_fs) |=> $stable(ovr_pin)); // R3
  AST_STAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_n && !word_stb) |=> $stable(ovr_stat)); // R4
  AST_STB_CLEARS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    word_stb |=> !sticky); // R5
  AST_FAST_SETS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_n && fast) |=> ovr_pin); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fs_cnt <= FSW'(RUN)); // R7
  AST_SETTLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_pin || ovr_stat) |-> settle_clr); // R8
endmodule

// File: tb/sim_ovr_watch.sv
module sim_ovr_watch;
  logic        clk = 0, rst_n = 0, sync_n = 1, s1_valid = 0, mod_fs = 0, word_stb = 0;
  logic [23:0] s1_data = '0;
  logic [15:0] thresh = 16'hCCCC;
  logic        ovr_pin, ovr_stat, settle_clr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ovr_watch u0 (.clk, .rst_n, .sync_n, .s1_valid, .s1_data, .thresh,
                .mod_fs, .word_stb, .ovr_pin, .ovr_stat, .settle_clr);

  int m_pin, m_stat, m_acc, m_run;

  function automatic int is_over(logic [23:0] d, logic [15:0] t);
    longint v, m;
    v = longint'($signed(d));
    m = (v < 0) ? -v : v;
    if (m > 64'sh7FFFFF) m = 64'sh7FFFFF;
    return ((m >> 7) > longint'(t)) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pin = 0; m_stat = 0; m_acc = 0; m_run = 0;
    end else if (!sync_n) begin
      m_pin = 0; m_stat = 0; m_acc = 0; m_run = 0;
    end else begin
      int f, h;
      f = (mod_fs && m_run >= 4) ? 1 : 0;
      h = f || (s1_valid && is_over(s1_data, thresh));
      if (f) m_pin = 1;
      else if (s1_valid) m_pin = is_over(s1_data, thresh);
      if (word_stb) begin m_stat = m_acc | h; m_acc = 0; end
      else if (h) m_acc = 1;
      m_run = mod_fs ? m_run + 1 : 0;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R3 pin vs model", ovr_pin, m_pin);
    check("R4 status vs model", ovr_stat, m_stat);
    check("R8 settle clear", settle_clr, ovr_pin | ovr_stat);
  end

  task automatic drive(logic v, logic [23:0] d, logic fs, logic stb, logic sn);
    @(negedge clk);
    s1_valid = v; s1_data = d; mod_fs = fs; word_stb = stb; sync_n = sn;
    @(posedge clk); #1;
  endtask

  task automatic idle(); drive(0, 24'h0, 0, 0, 1); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run ended)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset pin", ovr_pin, 0);
    check("R1 reset stat", ovr_stat, 0);
    check("R8 reset settle", settle_clr, 0);
    rst_n = 1;
    idle();

    drive(1, 24'h700000, 0, 0, 1); check("R3 over sets pin", ovr_pin, 1);
    check("R8 settle with pin", settle_clr, 1);
    idle(); check("R3 pin holds", ovr_pin, 1);
    drive(1, 24'h100000, 0, 0, 1); check("R3 low sample clears pin", ovr_pin, 0);
    drive(0, 24'h0, 0, 1, 1); check("R4 sticky copied", ovr_stat, 1);
    drive(0, 24'h0, 0, 1, 1); check("R5 accumulator cleared", ovr_stat, 0);

    drive(1, 24'h666600, 0, 0, 1); check("R2 equal is not over", ovr_pin, 0);
    drive(1, 24'h666680, 0, 0, 1); check("R2 one above is over", ovr_pin, 1);
    drive(1, 24'h100000, 0, 0, 1);
    drive(1, 24'h800000, 0, 0, 1); check("R2 most negative saturates", ovr_pin, 1);
    drive(1, 24'h100000, 0, 0, 1);
    drive(1, 24'h900000, 0, 0, 1); check("R2 negative magnitude", ovr_pin, 1);
    drive(1, 24'hF00000, 0, 0, 1); check("R2 small negative", ovr_pin, 0);
    drive(0, 24'h0, 0, 1, 1);

    drive(1, 24'h700000, 0, 1, 1); check("R5 strobe-cycle sample counted", ovr_stat, 1);
    drive(1, 24'h000100, 0, 0, 1);
    drive(0, 24'h0, 0, 1, 1); check("R5 not carried to next word", ovr_stat, 0);

    for (int i = 0; i < 4; i++) drive(0, 24'h0, 1, 0, 1);
    check("R7 four flags do not raise", ovr_pin, 0);
    drive(0, 24'h0, 1, 1, 1); check("R6 fifth flag raises pin", ovr_pin, 1);
    check("R6 fifth flag in strobe word", ovr_stat, 1);
    drive(1, 24'h000100, 0, 0, 1);
    for (int i = 0; i < 3; i++) drive(0, 24'h0, 1, 0, 1);
    idle();
    for (int i = 0; i < 4; i++) drive(0, 24'h0, 1, 0, 1);
    check("R7 broken run", ovr_pin, 0);
    drive(1, 24'h000100, 1, 0, 1); check("R6 priority over low sample", ovr_pin, 1);
    drive(0, 24'h0, 0, 1, 1);

    for (int i = 0; i < 3; i++) drive(0, 24'h0, 1, 0, 1);
    drive(0, 24'h0, 1, 0, 0);
    check("R1 sync clears pin", ovr_pin, 0);
    check("R1 sync clears stat", ovr_stat, 0);
    for (int i = 0; i < 4; i++) drive(0, 24'h0, 1, 0, 1);
    check("R1 sync cleared run counter", ovr_pin, 0);
    idle();

    thresh = 16'h1000;
    drive(1, 24'h100000, 0, 0, 1); check("R9 lowered threshold", ovr_pin, 1);
    thresh = 16'hCCCC;
    drive(1, 24'h100000, 0, 0, 1); check("R9 restored threshold", ovr_pin, 0);

    for (int i = 0; i < 6000; i++) begin
      logic [23:0] d;
      d = $urandom();
      if ($urandom_range(0, 19) == 0) thresh = $urandom();
      drive($urandom_range(0, 3) == 0, d, $urandom_range(0, 9) < 6,
            $urandom_range(0, 15) == 0, $urandom_range(0, 99) != 0);
    end
    idle(); idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule